// File: doc/BRIEF.md
# Two-Wire Bus Recovery and Acknowledge-Poll Master

This block is a small master-side sequencer for a two-wire serial bus. It produces the clock line and an open-drain data line from the system clock. The low and high phases of the bus clock are each set by a parameter counted in system clock cycles. The block runs one of two commands. Both lines are modelled as open-drain: an output high means the block pulls that line low, and an output low leaves the line to the pull-up.

The recovery command frees a slave that is stuck mid-byte after an interrupted transfer. It sends this fixed pattern:

- a start condition;
- nine clock pulses with data released;
- a second start;
- a stop at once after the second start.

After the pattern the bus is idle and ready for a new transfer.

The poll command checks whether a slave has finished its internal write cycle. Each attempt sends:

1. a start;
2. the 7-bit slave address followed by the read/write bit;
3. a ninth clock with data released, during which the acknowledge is sampled.

The attempt always ends with a stop. A low sample ends the command as acknowledged. A high sample means the slave is still busy. The block then waits a bus-free interval and tries again, until a maximum attempt count is reached and a timeout is reported.

Top module: `twb_recover_poll`

## Requirements
- R1: After reset, and whenever `busy` is low, both line outputs are released (`sclDriveLow` = 0, `sdaDriveLow` = 0), and `done`, `acked`, `timeout` and `attempts` read 0 after reset.
- R2: A command accepted with `cmdPoll` = 0 puts this sequence on the bus:
  - a start;
  - nine clock pulses, each sampling data high;
  - a start;
  - a stop.
  After the sequence both lines are released, and `done` reports `acked` = 0, `timeout` = 0, `attempts` = 0.
- R3: A command accepted with `cmdPoll` = 1 makes each attempt a start followed by eight data bits, most significant first:
  - the seven bits of `cmdAddr` as captured at acceptance;
  - then `cmdRead`.
  These are followed by a ninth clock with data released, and then a stop.
- R4: The acknowledge is the data line sampled during the ninth clock's high phase, where low means acknowledged. On an acknowledge the block issues a stop and then signals `done` with `acked` = 1, `timeout` = 0 and `attempts` equal to the number of attempts made.
- R5: The data output changes only while the clock line is low, except when it forms a start or stop. It never changes in the same system cycle as the clock output.
- R6: After a non-acknowledged attempt the block issues a stop and keeps the bus idle for at least FREE_CYCLES system cycles before the next start.
- R7: When MAX_TRIES attempts in a row are not acknowledged, the block signals `done` with `timeout` = 1, `acked` = 0 and `attempts` = MAX_TRIES. An acknowledge on attempt MAX_TRIES still reports `acked` = 1.
- R8: Every clock low phase lasts LOW_CYCLES system cycles. Every high phase of a data or acknowledge bit lasts HIGH_CYCLES system cycles.
- R9: `cmdValid` is ignored while `busy` is high. The bus sequence and the reported results of the running command are unchanged.
- R10: `busy` rises in the cycle after a command is accepted and stays high until `done`. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Start a command; accepted only while idle |
| cmdPoll | input | 1 | 0 = recovery sequence, 1 = acknowledge poll |
| cmdAddr | input | ADDR_BITS | Slave address for a poll |
| cmdRead | input | 1 | Read/write bit sent after the address |
| sdaIn | input | 1 | Sampled level of the data line |
| sclDriveLow | output | 1 | 1 pulls the clock line low |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command completion |
| acked | output | 1 | Last poll was acknowledged (valid at `done`) |
| timeout | output | 1 | Poll gave up after MAX_TRIES attempts (valid at `done`) |
| attempts | output | clog2(MAX_TRIES+1) | Number of poll attempts made |

## Verification
The bench pulls the data line low during the acknowledge slot only after a set number of address matches have gone unanswered. This exercises the following cases:

- an acknowledge on the first attempt;
- an acknowledge on a middle attempt;
- an acknowledge on exactly the last allowed attempt, where an off-by-one in the attempt limit would report a timeout;
- a slave that never answers, where a design that never gives up would hang;
- an address the slave does not recognise.

A decoder rebuilds starts, stops and bits from the lines, which catches the following faults:

- a recovery sequence with eight or ten dummy clocks, or with the final stop missing;
- address bits in the wrong order;
- an address taken live rather than captured at acceptance.

Phase-length and edge-order checks catch data moving in the same cycle as the clock, or a short bus-free gap. A command pulsed mid-poll shows whether the block wrongly restarts.

// File: rtl/twb_pkg.sv
package twb_pkg;

  // Which duration the phase timer loads on a state change.
  typedef enum logic [1:0] {
    TM_LOW,
    TM_HIGH,
    TM_FREE,
    TM_ONE
  } timeSelE;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic    sclLow;
    logic    sdaLow;
    logic    sdaHold;
    logic    loadTimer;
    timeSelE timeSel;
    logic    latchWord;
    logic    reloadShift;
    logic    shiftNext;
    logic    clrBits;
    logic    incBits;
    logic    clrStatus;
    logic    incAttempt;
    logic    sampleAck;
  } ctlStrobeT;

  // Status from the datapath back to the sequencer.
  typedef struct packed {
    logic timerDone;
    logic lastBit;
    logic shiftMsb;
    logic ackSeen;
    logic triesSpent;
  } dpStatusT;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_SU,
    S_START_HD,
    S_FALL,
    S_LOW,
    S_HIGH,
    S_STOP_HI,
    S_FREE,
    S_DONE
  } seqStateE;

  // Purpose of the current clock-low phase.
  typedef enum logic [1:0] {
    LK_BIT,
    LK_PRESTART,
    LK_PRESTOP
  } lowKindE;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/twb_bit_datapath.sv
module twb_bit_datapath
  import twb_pkg::*;
#(
  parameter int LOW_CYCLES  = 63,
  parameter int HIGH_CYCLES = 62,
  parameter int FREE_CYCLES = 65,
  parameter int MAX_TRIES   = 16,
  parameter int ADDR_BITS   = 7
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctlStrobeT                        ctl,
  input  logic [ADDR_BITS:0]               cmdWord,
  input  logic                             sdaIn,
  output dpStatusT                         st,
  output logic                             sclLowQ,
  output logic                             sdaLowQ,
  output logic [$clog2(MAX_TRIES+1)-1:0]   triesQ
);

  localparam int WORD_BITS = ADDR_BITS + 1;
  localparam int LONGEST   = maxOf3(LOW_CYCLES, HIGH_CYCLES, FREE_CYCLES);
  localparam int CNT_W     = $clog2(LONGEST + 1);
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);
  localparam int BIT_W     = $clog2(WORD_BITS + 1);

  // The one-cycle fall state precedes every low phase, so the low load is two short.
  localparam logic [CNT_W-1:0] LOAD_LOW  = CNT_W'(LOW_CYCLES - 2);
  localparam logic [CNT_W-1:0] LOAD_HIGH = CNT_W'(HIGH_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOAD_FREE = CNT_W'(FREE_CYCLES - 1);
  localparam logic [TRY_W-1:0] TRY_CAP   = TRY_W'(MAX_TRIES);
  localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(WORD_BITS);

  logic [CNT_W-1:0]     timerQ;
  logic [WORD_BITS-1:0] wordQ;
  logic [WORD_BITS-1:0] shiftQ;
  logic [BIT_W-1:0]     bitQ;
  logic                 ackQ;

  // Phase timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (ctl.loadTimer) begin
      unique case (ctl.timeSel)
        TM_LOW:  timerQ <= LOAD_LOW;
        TM_HIGH: timerQ <= LOAD_HIGH;
        TM_FREE: timerQ <= LOAD_FREE;
        default: timerQ <= '0;
      endcase
    end else if (timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
    end
  end

  // Address word capture and shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      shiftQ <= '0;
    end else if (ctl.latchWord) begin
      wordQ  <= cmdWord;
      shiftQ <= cmdWord;
    end else if (ctl.reloadShift) begin
      shiftQ <= wordQ;
    end else if (ctl.shiftNext) begin
      shiftQ <= {shiftQ[WORD_BITS-2:0], 1'b0};
    end
  end

  // Bit position within the current frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitQ <= '0;
    end else if (ctl.clrBits) begin
      bitQ <= '0;
    end else if (ctl.incBits) begin
      bitQ <= bitQ + 1'b1;
    end
  end

  // Attempt counter and acknowledge sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      triesQ <= '0;
      ackQ   <= 1'b0;
    end else begin
      if (ctl.clrStatus) begin
        triesQ <= '0;
      end else if (ctl.incAttempt) begin
        triesQ <= triesQ + 1'b1;
      end
      if (ctl.clrStatus) begin
        ackQ <= 1'b0;
      end else if (ctl.sampleAck) begin
        ackQ <= !sdaIn;
      end
    end
  end

  // Registered line drivers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclLowQ <= 1'b0;
      sdaLowQ <= 1'b0;
    end else begin
      sclLowQ <= ctl.sclLow;
      if (!ctl.sdaHold) begin
        sdaLowQ <= ctl.sdaLow;
      end
    end
  end

  assign st.timerDone  = (timerQ == '0);
  assign st.lastBit    = (bitQ == ACK_SLOT);
  assign st.shiftMsb   = shiftQ[WORD_BITS-1];
  assign st.ackSeen    = ackQ;
  assign st.triesSpent = (triesQ == TRY_CAP);

  // R5: data never moves in the same cycle as the clock line
  a_r5_sda_stable_on_scl_edge : assert property (
    @(posedge clk) disable iff (!rstN)
    (sclLowQ != $past(sclLowQ)) |-> (sdaLowQ == $past(sdaLowQ))
  ) else $error("R5 data changed with clock edge");

  // R7: attempt count never passes the limit
  a_r7_tries_capped : assert property (
    @(posedge clk) disable iff (!rstN)
    triesQ <= TRY_CAP
  ) else $error("R7 attempt count above limit");

endmodule

// File: rtl/twb_seq_ctrl.sv
module twb_seq_ctrl
  import twb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdPoll,
  input  dpStatusT  st,
  output ctlStrobeT ctl,
  output logic      busy,
  output logic      done,
  output logic      timeout
);

  seqStateE stateQ, stateD;
  lowKindE  kindQ, kindD;
  logic     pollQ, pollD;
  logic     secondQ, secondD;
  logic     timeoutQ, timeoutD;
  logic     bitDrivesLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      kindQ    <= LK_BIT;
      pollQ    <= 1'b0;
      secondQ  <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      kindQ    <= kindD;
      pollQ    <= pollD;
      secondQ  <= secondD;
      timeoutQ <= timeoutD;
    end
  end

  always_comb begin
    ctl          = '0;
    stateD       = stateQ;
    kindD        = kindQ;
    pollD        = pollQ;
    secondD      = secondQ;
    timeoutD     = timeoutQ;
    // Only address bits of a poll pull data low; dummy clocks and the ack slot release it.
    bitDrivesLow = pollQ && !st.lastBit && !st.shiftMsb;

    unique case (stateQ)
      S_IDLE: begin
        if (cmdValid) begin
          pollD         = cmdPoll;
          secondD       = 1'b0;
          timeoutD      = 1'b0;
          ctl.latchWord = 1'b1;
          ctl.clrStatus = 1'b1;
          ctl.loadTimer = 1'b1;
          ctl.timeSel   = TM_HIGH;
          stateD        = S_START_SU;
        end
      end

      S_START_SU: begin
        if (st.timerDone) begin
          ctl.loadTimer  = 1'b1;
          ctl.timeSel    = TM_HIGH;
          ctl.incAttempt = pollQ;
          stateD         = S_START_HD;
        end
      end

      S_START_HD: begin
        ctl.sdaLow = 1'b1;
        if (st.timerDone) begin
          ctl.loadTimer = 1'b1;
          ctl.timeSel   = TM_ONE;
          ctl.clrBits   = 1'b1;
          kindD         = (!pollQ && secondQ) ? LK_PRESTOP : LK_BIT;
          stateD        = S_FALL;
        end
      end

      S_FALL: begin
        ctl.sclLow  = 1'b1;
        ctl.sdaHold = 1'b1;
        if (st.timerDone) begin
          ctl.loadTimer = 1'b1;
          ctl.timeSel   = TM_LOW;
          stateD        = S_LOW;
        end
      end

      S_LOW: begin
        ctl.sclLow = 1'b1;
        unique case (kindQ)
          LK_PRESTOP:  ctl.sdaLow = 1'b1;
          LK_PRESTART: ctl.sdaLow = 1'b0;
          default:     ctl.sdaLow = bitDrivesLow;
        endcase
        if (st.timerDone) begin
          ctl.loadTimer = 1'b1;
          ctl.timeSel   = TM_HIGH;
          unique case (kindQ)
            LK_PRESTOP: stateD = S_STOP_HI;
            LK_PRESTART: begin
              secondD = 1'b1;
              stateD  = S_START_SU;
            end
            default: stateD = S_HIGH;
          endcase
        end
      end

      S_HIGH: begin
        ctl.sdaLow = bitDrivesLow;
        if (st.timerDone) begin
          ctl.loadTimer = 1'b1;
          ctl.timeSel   = TM_ONE;
          stateD        = S_FALL;
          if (st.lastBit) begin
            ctl.sampleAck = pollQ;
            kindD         = pollQ ? LK_PRESTOP : LK_PRESTART;
          end else begin
            ctl.shiftNext = 1'b1;
            ctl.incBits   = 1'b1;
            kindD         = LK_BIT;
          end
        end
      end

      S_STOP_HI: begin
        ctl.sdaLow = 1'b1;
        if (st.timerDone) begin
          ctl.loadTimer = 1'b1;
          ctl.timeSel   = TM_FREE;
          stateD        = S_FREE;
        end
      end

      S_FREE: begin
        if (st.timerDone) begin
          if (!pollQ || st.ackSeen) begin
            stateD = S_DONE;
          end else if (st.triesSpent) begin
            timeoutD = 1'b1;
            stateD   = S_DONE;
          end else begin
            ctl.reloadShift = 1'b1;
            ctl.loadTimer   = 1'b1;
            ctl.timeSel     = TM_HIGH;
            stateD          = S_START_SU;
          end
        end
      end

      S_DONE: stateD = S_IDLE;

      default: stateD = S_IDLE;
    endcase
  end

  assign busy    = (stateQ != S_IDLE);
  assign done    = (stateQ == S_DONE);
  assign timeout = timeoutQ;

  // R10: completion is a single-cycle pulse
  a_r10_done_single : assert property (
    @(posedge clk) disable iff (!rstN)
    done |=> !done
  ) else $error("R10 done held for more than one cycle");

  // R7: timeout is only raised once the attempt limit is used up
  a_r7_timeout_at_limit : assert property (
    @(posedge clk) disable iff (!rstN)
    $rose(timeoutQ) |-> st.triesSpent
  ) else $error("R7 timeout before attempt limit");

endmodule

// File: rtl/twb_recover_poll.sv
module twb_recover_poll
  import twb_pkg::*;
#(
  parameter int LOW_CYCLES  = 63,
  parameter int HIGH_CYCLES = 62,
  parameter int FREE_CYCLES = 65,
  parameter int MAX_TRIES   = 16,
  parameter int ADDR_BITS   = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdValid,
  input  logic                           cmdPoll,
  input  logic [ADDR_BITS-1:0]           cmdAddr,
  input  logic                           cmdRead,
  input  logic                           sdaIn,
  output logic                           sclDriveLow,
  output logic                           sdaDriveLow,
  output logic                           busy,
  output logic                           done,
  output logic                           acked,
  output logic                           timeout,
  output logic [$clog2(MAX_TRIES+1)-1:0] attempts
);

  ctlStrobeT ctl;
  dpStatusT  st;

  twb_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdPoll  (cmdPoll),
    .st       (st),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout)
  );

  twb_bit_datapath #(
    .LOW_CYCLES  (LOW_CYCLES),
    .HIGH_CYCLES (HIGH_CYCLES),
    .FREE_CYCLES (FREE_CYCLES),
    .MAX_TRIES   (MAX_TRIES),
    .ADDR_BITS   (ADDR_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cmdWord ({cmdAddr, cmdRead}),
    .sdaIn   (sdaIn),
    .st      (st),
    .sclLowQ (sclDriveLow),
    .sdaLowQ (sdaDriveLow),
    .triesQ  (attempts)
  );

  assign acked = st.ackSeen;

  // R1: an idle block leaves both lines released
  a_r1_idle_released : assert property (
    @(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow)
  ) else $error("R1 line driven while idle");

  // R4: acknowledge and timeout are never reported together
  a_r4_ack_timeout_exclusive : assert property (
    @(posedge clk) disable iff (!rstN)
    !(acked && timeout)
  ) else $error("R4 acked and timeout both set");

endmodule

// File: tb/twb_recover_poll_tb.sv
module twb_recover_poll_tb;

  localparam int LOWC  = 6;
  localparam int HIGHC = 5;
  localparam int FREEC = 8;
  localparam int TRIES = 4;
  localparam logic [6:0] SLAVE_ID = 7'h50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdPoll = 1'b0;
  logic [6:0] cmdAddr = '0;
  logic       cmdRead = 1'b0;
  logic       sdaIn;
  logic       sclDriveLow, sdaDriveLow, busy, done, acked, timeout;
  logic [2:0] attempts;
  logic       slaveLow = 1'b0;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  int busyLeft = 0;

  always #5 clk = ~clk;

  assign sdaIn = !sdaDriveLow && !slaveLow;

  twb_recover_poll #(
    .LOW_CYCLES (LOWC),
    .HIGH_CYCLES(HIGHC),
    .FREE_CYCLES(FREEC),
    .MAX_TRIES  (TRIES),
    .ADDR_BITS  (7)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPoll(cmdPoll),
    .cmdAddr(cmdAddr), .cmdRead(cmdRead), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .busy(busy),
    .done(done), .acked(acked), .timeout(timeout), .attempts(attempts)
  );

  function automatic void check(input bit ok, input string req, input string what,
                                input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  // Scoreboard pop: 0/1 = data bit, 2 = start, 3 = stop
  function automatic void expectEvt(input int got);
    if (expQ.size() == 0) begin
      check(1'b0, "R2/R3", "unexpected bus event", got, -1);
    end else begin
      int exp;
      exp = expQ.pop_front();
      check(got == exp, "R2/R3", "bus event", got, exp);
    end
  endfunction

  // Bus monitor, slave model and timing checks
  logic prevScl = 1'b1, prevSda = 1'b1, prevSdaD = 1'b0, pend = 1'b0, pendVal = 1'b0;
  int   cyc = 0, edgeCyc = 0, stopCyc = 0, slaveIdx = 0;
  bit   haveStop = 1'b0;
  logic [7:0] slaveByte = '0;

  always @(negedge clk) begin : mon
    logic sclB, sdaB;
    cyc++;
    sclB = !sclDriveLow;
    sdaB = !sdaDriveLow && !slaveLow;
    if (rstN) begin
      // R5: data output never toggles in the same cycle as the clock output
      if ((sclB != prevScl) && (sdaDriveLow != prevSdaD))
        check(1'b0, "R5", "data moved with clock edge", cyc, 0);
      if (sclB && prevScl && prevSda && !sdaB) begin
        pend = 1'b0;
        expectEvt(2);
        if (haveStop) check(cyc - stopCyc >= FREEC, "R6", "bus free gap", cyc - stopCyc, FREEC);
        haveStop  = 1'b0;
        slaveIdx  = 0;
        slaveByte = '0;
        slaveLow  = 1'b0;
      end else if (sclB && prevScl && !prevSda && sdaB) begin
        pend = 1'b0;
        expectEvt(3);
        haveStop = 1'b1;
        stopCyc  = cyc;
      end
      if (!prevScl && sclB) begin
        check(cyc - edgeCyc == LOWC, "R8", "clock low length", cyc - edgeCyc, LOWC);
        pend    = 1'b1;
        pendVal = sdaB;
        edgeCyc = cyc;
      end
      if (prevScl && !sclB) begin
        if (pend) begin
          check(cyc - edgeCyc == HIGHC, "R8", "clock high length", cyc - edgeCyc, HIGHC);
          expectEvt(int'(pendVal));
          slaveIdx++;
          if (slaveIdx <= 8) slaveByte = {slaveByte[6:0], pendVal};
          if (slaveIdx == 8) begin
            if (slaveByte[7:1] == SLAVE_ID) begin
              if (busyLeft == 0) slaveLow = 1'b1;
              else busyLeft--;
            end
          end else if (slaveIdx == 9) begin
            slaveLow = 1'b0;
          end
        end
        pend    = 1'b0;
        edgeCyc = cyc;
      end
    end
    prevScl  = sclB;
    prevSda  = sdaB;
    prevSdaD = sdaDriveLow;
  end

  // Driver: pushes the expected bus stream, issues the command, checks the results
  task automatic runCmd(input bit poll, input logic [6:0] addr, input bit rd,
                        input int nBusy, input int interject, input string req);
    int  n;
    bit  ackOk;
    int  w;
    logic [7:0] word;
    word = {addr, rd};
    if (!poll) begin
      n = 0;
      ackOk = 1'b0;
      expQ.push_back(2);
      for (int i = 0; i < 9; i++) expQ.push_back(1);
      expQ.push_back(2);
      expQ.push_back(3);
    end else begin
      if ((addr == SLAVE_ID) && (nBusy < TRIES)) begin
        n = nBusy + 1;
        ackOk = 1'b1;
      end else begin
        n = TRIES;
        ackOk = 1'b0;
      end
      for (int a = 0; a < n; a++) begin
        expQ.push_back(2);
        for (int b = 7; b >= 0; b--) expQ.push_back(int'(word[b]));
        expQ.push_back((ackOk && (a == n - 1)) ? 0 : 1);
        expQ.push_back(3);
      end
    end
    busyLeft = nBusy;
    @(negedge clk);
    cmdValid = 1'b1;
    cmdPoll  = poll;
    cmdAddr  = addr;
    cmdRead  = rd;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdAddr  = ~addr;
    cmdRead  = ~rd;
    check(busy == 1'b1, "R10", {req, " busy after accept"}, int'(busy), 1);
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
      // R9: a command pulsed while busy must be ignored
      cmdValid = (interject > 0) && (w == interject);
      cmdPoll  = !poll;
    end
    cmdValid = 1'b0;
    check(done == 1'b1, "R10", {req, " done seen"}, int'(done), 1);
    check(acked == ackOk, poll ? "R4" : "R2", {req, " acked"}, int'(acked), int'(ackOk));
    check(timeout == (poll && !ackOk), "R7", {req, " timeout"}, int'(timeout), int'(poll && !ackOk));
    check(int'(attempts) == n, poll ? "R4/R7" : "R2", {req, " attempts"}, int'(attempts), n);
    @(negedge clk);
    check(done == 1'b0, "R10", {req, " done single pulse"}, int'(done), 0);
    check(busy == 1'b0, "R10", {req, " idle after done"}, int'(busy), 0);
    check(expQ.size() == 0, "R2/R3", {req, " stream complete"}, expQ.size(), 0);
    check(!sclDriveLow && !sdaDriveLow, "R1", {req, " lines released"},
          int'({sclDriveLow, sdaDriveLow}), 0);
    expQ.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!sclDriveLow && !sdaDriveLow, "R1", "lines released after reset",
          int'({sclDriveLow, sdaDriveLow}), 0);
    check(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    check(!acked && !timeout && attempts == 0, "R1", "status after reset",
          int'({acked, timeout, attempts}), 0);

    runCmd(1'b0, 7'h00, 1'b0, 0, 0, "R2 recovery");
    runCmd(1'b1, SLAVE_ID, 1'b0, 0, 0, "R4 ack first try");
    runCmd(1'b1, SLAVE_ID, 1'b1, 2, 0, "R4 ack third try R3 read bit");
    runCmd(1'b1, SLAVE_ID, 1'b0, 10, 0, "R7 never acked R6");
    runCmd(1'b1, SLAVE_ID, 1'b0, TRIES - 1, 0, "R7 ack on last try");
    runCmd(1'b1, 7'h51, 1'b0, 0, 0, "R7 wrong address");
    runCmd(1'b1, SLAVE_ID, 1'b0, 1, 30, "R9 command while busy");
    runCmd(1'b0, 7'h00, 1'b0, 0, 40, "R9 R2 recovery interjected");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule